// File: doc/BRIEF.md
# SPI Direct-Mode Switch and Pin Multiplexer

This block sits behind the SPI slave pins of a reader front end. It watches the serial command stream, which is sampled on the system clock, together with the chip-select line, and decides when the device leaves normal register traffic for a direct mode. In direct mode the host drives the RF modulation itself and reads raw receive signals, with no protocol handling in between.

In direct mode the four SPI pins take new roles:
- the serial data input sets the field level;
- the serial clock input enables the receiver;
- the serial data output and the interrupt line carry receive signals.

A select input chooses which pair of receive signals appears on those two outputs: either the decoded bit stream with its bit clock, or the in-phase and quadrature subcarriers. Outside direct mode the two outputs carry the normal SPI read data and interrupt request. The receive signals and the SPI read data come from other blocks and are primary inputs here.

Commands are shifted in MSB first, one bit on each rising serial-clock edge while chip select is low. A byte is complete after eight such edges.

Top module: `spi_direct_switch`

## Requirements
- R1: After reset, `direct_active`, `field_out` and `rx_enable` are 0, `miso` equals `spi_rd_data` and `irq` equals `irq_norm`.
- R2: When the last complete byte of a low-`ncs` frame is 0x81 (bits shifted MSB first on rising `sclk` while `ncs` is low) and no further bits follow it, `direct_active` rises on the clock edge that first samples `ncs` high. Every other byte value leaves the mode off.
- R3: While `direct_active` is 1 and `ncs` stays high, the mode stays on, whatever `sclk` and `mosi` do.
- R4: In direct mode, a 0x96 byte that is the first complete byte after `ncs` falls clears `direct_active` on the edge that samples its eighth rising `sclk`. Any other first byte, and a 0x96 that is not the first byte, leaves the mode on, including across the next `ncs` rise.
- R5: Entry is cancelled, and needs a new 0x81 later, in two cases: when `ncs` rises after 0x81 with a partial byte shifted in, or when a further complete byte that is not 0x81 follows 0x81.
- R6: `field_out` equals `mosi` while `direct_active` is 1 and is 0 otherwise.
- R7: `rx_enable` equals `sclk` while `direct_active` is 1 and is 0 otherwise.
- R8: In direct mode with `dir_sel` = 0, `miso` equals `rx_bit` and `irq` equals `rx_bclk`.
- R9: In direct mode with `dir_sel` = 1, `miso` equals `rx_i` and `irq` equals `rx_q`.
- R10: Outside direct mode, `miso` equals `spi_rd_data` and `irq` equals `irq_norm`, whatever `dir_sel` and the receive inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ncs | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock / receive enable in direct mode |
| mosi | input | 1 | Serial data in / field level in direct mode |
| dir_sel | input | 1 | Receive-output select: 0 bit stream, 1 subcarriers |
| spi_rd_data | input | 1 | Normal SPI read data from the register side |
| irq_norm | input | 1 | Normal interrupt request |
| rx_bit | input | 1 | Decoded receive bit stream |
| rx_bclk | input | 1 | Receive bit clock |
| rx_i | input | 1 | In-phase subcarrier |
| rx_q | input | 1 | Quadrature subcarrier |
| miso | output | 1 | Serial data out or receive signal |
| irq | output | 1 | Interrupt or receive signal |
| field_out | output | 1 | Transmit field level |
| rx_enable | output | 1 | Receiver enable |
| direct_active | output | 1 | Direct mode is on |

## Verification
The exit command shares its pins with the direct-mode functions. While 0x96 is shifted in, each of its bits is at the same time a field-level sample on `field_out`. The eighth serial-clock rise both completes the command and, in that same cycle, is passed through as `rx_enable`. The bench checks `field_out` against `mosi` in the middle of the exit byte. After the byte it drives `mosi` high and expects `field_out` to be 0, which shows the mode ended on that exact edge and not one later. The entry and exit sweeps cover all 256 byte values.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic { MODE_NORMAL = 1'b0, MODE_DIRECT = 1'b1 } mode_t;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam logic [7:0] ENTER_CODE_DEF = 8'h81;
  localparam logic [7:0] EXIT_CODE_DEF  = 8'h96;
  localparam int unsigned LANES = 2;  // lane 0: miso, lane 1: irq
endpackage

// File: rtl/dsw_byte_capture.sv
module dsw_byte_capture #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ncs,
  input  logic              sclk,
  input  logic              mosi,
  output logic              ncs_rise,
  output logic              byte_fire,
  output logic              byte_first,
  output logic              mid_byte,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              ncs_q, sclk_q, first_q, first_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic              sclk_rise;

  assign ncs_rise   = ncs & ~ncs_q;
  assign sclk_rise  = sclk & ~sclk_q & ~ncs;
  assign byte_fire  = sclk_rise && (cnt_q == LAST);
  assign byte_val   = {sh_q, mosi};
  assign byte_first = first_q;
  assign mid_byte   = (cnt_q != '0);

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    first_d = first_q;
    if (ncs) begin
      cnt_d   = '0;
      first_d = 1'b1;
    end else if (sclk_rise) begin
      sh_d = byte_val[BYTE_W-2:0];
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        first_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ncs_q   <= 1'b1;
      sclk_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      first_q <= 1'b1;
    end else begin
      ncs_q   <= ncs;
      sclk_q  <= sclk;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/dsw_mode_seq.sv
module dsw_mode_seq
  import dsw_pkg::*;
#(
  parameter int unsigned       BYTE_W     = 8,
  parameter logic [BYTE_W-1:0] ENTER_CODE = BYTE_W'(ENTER_CODE_DEF),
  parameter logic [BYTE_W-1:0] EXIT_CODE  = BYTE_W'(EXIT_CODE_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ncs_rise,
  input  logic              byte_fire,
  input  logic              byte_first,
  input  logic              mid_byte,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              direct
);
  mode_t mode_q, mode_d;
  logic  armed_q, armed_d;

  always_comb begin
    mode_d  = mode_q;
    armed_d = armed_q;
    // armed follows the last complete byte; any chip-select rise clears it
    if (ncs_rise)       armed_d = 1'b0;
    else if (byte_fire) armed_d = (mode_q == MODE_NORMAL) && (byte_val == ENTER_CODE);
    unique case (mode_q)
      MODE_NORMAL: if (ncs_rise && armed_q && !mid_byte) mode_d = MODE_DIRECT;
      MODE_DIRECT: if (byte_fire && byte_first && byte_val == EXIT_CODE) mode_d = MODE_NORMAL;
      default:     mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORMAL;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      armed_q <= armed_d;
    end
  end

  assign direct = (mode_q == MODE_DIRECT);
endmodule

// File: rtl/dsw_pin_mux.sv
module dsw_pin_mux
  import dsw_pkg::*;
(
  input  logic direct,
  input  logic dir_sel,
  input  logic mosi,
  input  logic sclk,
  input  logic spi_rd_data,
  input  logic irq_norm,
  input  logic rx_bit,
  input  logic rx_bclk,
  input  logic rx_i,
  input  logic rx_q,
  output logic miso,
  output logic irq,
  output logic field_out,
  output logic rx_enable
);
  logic [LANES-1:0] norm_src, strm_src, sub_src, lane_out;

  assign norm_src = {irq_norm, spi_rd_data};
  assign strm_src = {rx_bclk, rx_bit};
  assign sub_src  = {rx_q, rx_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_out[g] = direct ? (dir_sel ? sub_src[g] : strm_src[g]) : norm_src[g];
  end

  assign miso      = lane_out[0];
  assign irq       = lane_out[1];
  assign field_out = direct & mosi;
  assign rx_enable = direct & sclk;
endmodule

// File: rtl/spi_direct_switch.sv
module spi_direct_switch
  import dsw_pkg::*;
#(
  parameter int unsigned       BYTE_W     = BYTE_W_DEF,
  parameter logic [BYTE_W-1:0] ENTER_CODE = BYTE_W'(ENTER_CODE_DEF),
  parameter logic [BYTE_W-1:0] EXIT_CODE  = BYTE_W'(EXIT_CODE_DEF)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ncs,
  input  logic sclk,
  input  logic mosi,
  input  logic dir_sel,
  input  logic spi_rd_data,
  input  logic irq_norm,
  input  logic rx_bit,
  input  logic rx_bclk,
  input  logic rx_i,
  input  logic rx_q,
  output logic miso,
  output logic irq,
  output logic field_out,
  output logic rx_enable,
  output logic direct_active
);
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic              ncs_rise, byte_fire, byte_first, mid_byte;
  logic [BYTE_W-1:0] byte_val;

  dsw_byte_capture #(.BYTE_W(BYTE_W)) u_cap (
    .clk(clk), .rst_n(rst_s), .ncs(ncs), .sclk(sclk), .mosi(mosi),
    .ncs_rise(ncs_rise), .byte_fire(byte_fire), .byte_first(byte_first),
    .mid_byte(mid_byte), .byte_val(byte_val)
  );

  dsw_mode_seq #(.BYTE_W(BYTE_W), .ENTER_CODE(ENTER_CODE), .EXIT_CODE(EXIT_CODE)) u_seq (
    .clk(clk), .rst_n(rst_s), .ncs_rise(ncs_rise), .byte_fire(byte_fire),
    .byte_first(byte_first), .mid_byte(mid_byte), .byte_val(byte_val),
    .direct(direct_active)
  );

  dsw_pin_mux u_mux (
    .direct(direct_active), .dir_sel(dir_sel), .mosi(mosi), .sclk(sclk),
    .spi_rd_data(spi_rd_data), .irq_norm(irq_norm), .rx_bit(rx_bit),
    .rx_bclk(rx_bclk), .rx_i(rx_i), .rx_q(rx_q), .miso(miso), .irq(irq),
    .field_out(field_out), .rx_enable(rx_enable)
  );
endmodule

// File: rtl/spi_direct_switch_chk.sv
module spi_direct_switch_chk (
  input logic clk,
  input logic rst_n,
  input logic ncs,
  input logic sclk,
  input logic mosi,
  input logic spi_rd_data,
  input logic miso,
  input logic field_out,
  input logic rx_enable,
  input logic direct_active
);
  assert_entry_on_ncs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(direct_active) |-> ($past(ncs) && !$past(ncs, 2)));
  assert_hold_while_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_active && ncs) |=> direct_active);
  assert_exit_only_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(direct_active) |-> !$past(ncs));
  assert_field_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    direct_active |-> (field_out == mosi));
  assert_rxen_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    direct_active |-> (rx_enable == sclk));
  assert_normal_miso_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_active |-> (miso == spi_rd_data && !field_out && !rx_enable));
endmodule

bind spi_direct_switch spi_direct_switch_chk u_chk (
  .clk(clk), .rst_n(rst_s), .ncs(ncs), .sclk(sclk), .mosi(mosi),
  .spi_rd_data(spi_rd_data), .miso(miso), .field_out(field_out),
  .rx_enable(rx_enable), .direct_active(direct_active)
);

// File: tb/spi_direct_switch_test.sv
module spi_direct_switch_test;
  logic clk = 1'b0;
  logic rst_n, ncs, sclk, mosi, dir_sel, spi_rd_data, irq_norm;
  logic rx_bit, rx_bclk, rx_i, rx_q;
  logic miso, irq, field_out, rx_enable, direct_active;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  spi_direct_switch uut (
    .clk(clk), .rst_n(rst_n), .ncs(ncs), .sclk(sclk), .mosi(mosi),
    .dir_sel(dir_sel), .spi_rd_data(spi_rd_data), .irq_norm(irq_norm),
    .rx_bit(rx_bit), .rx_bclk(rx_bclk), .rx_i(rx_i), .rx_q(rx_q),
    .miso(miso), .irq(irq), .field_out(field_out), .rx_enable(rx_enable),
    .direct_active(direct_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic send_bit(input logic b);
    mosi = b; sclk = 1'b0; cyc();
    sclk = 1'b1; cyc();
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic cs_low();  ncs = 1'b0; mosi = 1'b0; cyc(); endtask
  task automatic cs_high(); ncs = 1'b1; mosi = 1'b0; cyc(); endtask

  task automatic enter();
    cs_low(); send_byte(8'h81); cs_high();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ncs = 1'b1; sclk = 1'b0; mosi = 1'b0; dir_sel = 1'b0;
    spi_rd_data = 1'b1; irq_norm = 1'b0; rx_bit = 1'b0; rx_bclk = 1'b1;
    rx_i = 1'b0; rx_q = 1'b1;
    repeat (3) cyc();
    #1;
    chk(direct_active == 0 && field_out == 0 && rx_enable == 0, "R1 reset mode", direct_active, 0);
    chk(miso == 1 && irq == 0, "R1 reset pins", {miso, irq}, 2'b10);
    rst_n = 1'b1;
    repeat (4) cyc();

    // entry sweep over all byte values
    for (int b = 0; b < 256; b++) begin
      cs_low(); send_byte(8'(b)); cs_high();
      chk(direct_active == (b == 8'h81), "R2 entry code sweep", direct_active, b == 8'h81);
      if (!direct_active) begin
        spi_rd_data = b[0]; irq_norm = b[1]; dir_sel = b[2];
        {rx_bit, rx_bclk, rx_i, rx_q} = ~4'(b);
        #1;
        chk(miso == b[0] && irq == b[1], "R10 normal pins", {miso, irq}, {b[0], b[1]});
      end else begin
        cs_low(); send_byte(8'h96);
        chk(direct_active == 0, "R4 exit after entry", direct_active, 0);
        cs_high();
      end
    end

    // multiplexer sweep in direct mode
    enter();
    for (int v = 0; v < 32; v++) begin
      {dir_sel, rx_bit, rx_bclk, rx_i, rx_q} = 5'(v);
      spi_rd_data = ~rx_bit; irq_norm = ~rx_bclk;
      #1;
      if (!dir_sel)
        chk(miso == rx_bit && irq == rx_bclk, "R8 stream lanes", {miso, irq}, {rx_bit, rx_bclk});
      else
        chk(miso == rx_i && irq == rx_q, "R9 subcarrier lanes", {miso, irq}, {rx_i, rx_q});
    end

    // direct mode held while ncs high, field and enable follow pins
    for (int v = 0; v < 16; v++) begin
      mosi = v[0]; sclk = v[1]; cyc(); #1;
      chk(direct_active == 1, "R3 hold while ncs high", direct_active, 1);
      chk(field_out == v[0], "R6 field follows mosi", field_out, v[0]);
      chk(rx_enable == v[1], "R7 enable follows sclk", rx_enable, v[1]);
    end
    sclk = 1'b0; mosi = 1'b0; cyc();

    // exit sweep over all first bytes
    for (int b = 0; b < 256; b++) begin
      cs_low(); send_byte(8'(b));
      chk(direct_active == (b != 8'h96), "R4 exit code sweep", direct_active, b != 8'h96);
      if (direct_active) begin
        send_byte(8'h96);
        chk(direct_active == 1, "R4 second byte ignored", direct_active, 1);
        cs_high();
        chk(direct_active == 1, "R4 stays after ncs rise", direct_active, 1);
        cs_low(); send_byte(8'h96);
        chk(direct_active == 0, "R4 exit on later frame", direct_active, 0);
      end
      cs_high(); enter();
    end

    // exit byte collides with field output
    cs_low();
    for (int i = 7; i >= 4; i--) send_bit(i == 7 || i == 4);
    mosi = 1'b1; #1;
    chk(field_out == 1, "R6 field during exit byte", field_out, 1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    mosi = 1'b1; sclk = 1'b1; #1;
    chk(field_out == 0 && rx_enable == 0, "R6 R7 off after exit edge", {field_out, rx_enable}, 0);
    sclk = 1'b0; cs_high();

    // cancellation cases
    cs_low(); send_byte(8'h81); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); cs_high();
    chk(direct_active == 0, "R5 partial byte cancels", direct_active, 0);
    cs_low(); cs_high();
    chk(direct_active == 0, "R5 armed flag cleared", direct_active, 0);
    cs_low(); send_byte(8'h81); send_byte(8'h00); cs_high();
    chk(direct_active == 0, "R5 trailing byte cancels", direct_active, 0);
    cs_low(); send_byte(8'h00); send_byte(8'h81); cs_high();
    chk(direct_active == 1, "R2 code as last byte", direct_active, 1);
    cs_low(); send_byte(8'h96); cs_high();
    chk(direct_active == 0, "R4 final exit", direct_active, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule